// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block sits between a set of I/O devices and a processor core. It decides at each instruction boundary whether the core should break off and service a device. Every device presents a request line, a permission bit, a fixed 3-bit priority and an 8-bit vector. The core presents its own running priority and a one-cycle strobe that marks the end of each instruction.

When the strobe arrives, the block looks only at devices that are both permitted and requesting. It picks the one with the highest priority, and a lower index breaks a tie. It accepts that device only if its priority is strictly above the core's running priority. On acceptance it raises a one-cycle take pulse and a supervisor-mode request. At the same time it presents the winner's vector, the winner's priority as the core's new priority, and the address of the matching service-routine table entry. That address is the table base 0x0100 plus the vector.

Saving context, fetching the routine pointer and returning from the interrupt all belong to the core. This block only supplies the values those steps need.

Top module: `irq_arbiter`

## Requirements
- R1: A device takes part in arbitration only when both its request bit and its enable bit are 1. A device with only one of the two set never causes a take.
- R2: A take happens only when the winning priority is strictly greater than `cur_prio_i`. An equal or lower priority yields no take.
- R3: Among eligible devices, the one with the numerically highest priority wins.
- R4: When eligible devices share the highest priority, the lowest device index wins.
- R5: Requests are sampled only on a clock edge where `eoi_i` is 1. Without that strobe, `take_o` stays 0 whatever the requests are.
- R6: `take_o` and `super_o` are 1 together, for exactly the one cycle after the edge that sampled a qualifying `eoi_i`.
- R7: During a take, `vec_o` equals the winner's vector, and `new_prio_o` equals the winner's priority.
- R8: `isr_addr_o` always equals 0x0100 plus `vec_o`.
- R9: When no device qualifies at a strobe, `take_o` stays 0, and `vec_o` and `new_prio_o` keep their previous values.
- R10: While `rst` is 1 (synchronous, active high), `take_o`, `super_o`, `vec_o` and `new_prio_o` are all 0, so `isr_addr_o` reads 0x0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N_DEV | Per-device service request |
| en_i | input | N_DEV | Per-device interrupt permission |
| prio_i | input | N_DEV*3 | Device priorities; device k uses bits [3k+2:3k] |
| vec_i | input | N_DEV*8 | Device vectors; device k uses bits [8k+7:8k] |
| cur_prio_i | input | 3 | Running priority of the processor |
| eoi_i | input | 1 | End-of-instruction strobe |
| take_o | output | 1 | One-cycle interrupt-accept pulse |
| super_o | output | 1 | Supervisor-mode request, raised with the take |
| vec_o | output | 8 | Vector of the last accepted device |
| new_prio_o | output | 3 | Priority to run at after acceptance |
| isr_addr_o | output | 16 | Service-table entry address, 0x0100 + vector |

## Verification
The assertions assume that `eoi_i` is a true strobe that is never high on two consecutive cycles. The one-cycle pulse check depends on this. They also assume that `cur_prio_i` is stable around the sampling edge as seen through `$past`. The stimulus drives every input on the falling edge. It spaces strobes at least one idle cycle apart, in both the directed cases and the random phase, so these assumptions always hold. The random phase varies requests, enables, priorities and the running priority freely. A behavioural model then predicts every output on every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int PRIO_W = 3;
    localparam int VEC_W  = 8;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef struct packed {
        logic  hit;
        prio_t prio;
        vec_t  vec;
    } pick_t;

    function automatic logic outranks(input prio_t a, input prio_t b);
        return a > b;
    endfunction
endpackage

// File: rtl/irq_eligible.sv
module irq_eligible #(
    parameter int N_DEV = 8
) (
    input  logic [N_DEV-1:0] req_i,
    input  logic [N_DEV-1:0] en_i,
    output logic [N_DEV-1:0] elig_o
);
    for (genvar k = 0; k < N_DEV; k++) begin : g_dev
        assign elig_o[k] = req_i[k] & en_i[k];
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
#(
    parameter int N_DEV = 8
) (
    input  logic [N_DEV-1:0]        elig_i,
    input  logic [N_DEV*PRIO_W-1:0] prio_i,
    input  logic [N_DEV*VEC_W-1:0]  vec_i,
    output pick_t                   win_o
);
    always_comb begin
        win_o = '0;
        // Strict compare: an equal priority later in the scan never displaces an earlier index.
        for (int k = 0; k < N_DEV; k++) begin
            if (elig_i[k] &&
                (!win_o.hit || outranks(prio_t'(prio_i[k*PRIO_W +: PRIO_W]), win_o.prio))) begin
                win_o.hit  = 1'b1;
                win_o.prio = prio_i[k*PRIO_W +: PRIO_W];
                win_o.vec  = vec_i[k*VEC_W +: VEC_W];
            end
        end
    end
endmodule

// File: rtl/irq_grant.sv
module irq_grant
    import irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  eoi_i,
    input  prio_t cur_prio_i,
    input  pick_t win_i,
    output logic  take_o,
    output logic  super_o,
    output vec_t  vec_o,
    output prio_t new_prio_o
);
    logic accept;
    assign accept = eoi_i && win_i.hit && outranks(win_i.prio, cur_prio_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o     <= 1'b0;
            super_o    <= 1'b0;
            vec_o      <= '0;
            new_prio_o <= '0;
        end else begin
            take_o  <= accept;
            super_o <= accept;
            if (accept) begin
                vec_o      <= win_i.vec;
                new_prio_o <= win_i.prio;
            end
        end
    end

    AST_TAKE_AT_EOI: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(eoi_i)); // R5
    AST_PRIO_ABOVE: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (new_prio_o > $past(cur_prio_i))); // R2
    AST_TAKE_ONE: assert property (@(posedge clk) disable iff (rst)
        take_o |=> !take_o); // R6
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !take_o) |-> ($stable(vec_o) && $stable(new_prio_o))); // R9
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int          N_DEV    = 8,
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] TBL_BASE = 16'h0100
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_DEV-1:0]        req_i,
    input  logic [N_DEV-1:0]        en_i,
    input  logic [N_DEV*PRIO_W-1:0] prio_i,
    input  logic [N_DEV*VEC_W-1:0]  vec_i,
    input  logic [PRIO_W-1:0]       cur_prio_i,
    input  logic                    eoi_i,
    output logic                    take_o,
    output logic                    super_o,
    output logic [VEC_W-1:0]        vec_o,
    output logic [PRIO_W-1:0]       new_prio_o,
    output logic [ADDR_W-1:0]       isr_addr_o
);
    logic [N_DEV-1:0] elig;
    pick_t            win;

    irq_eligible #(.N_DEV(N_DEV)) u_elig (
        .req_i (req_i),
        .en_i  (en_i),
        .elig_o(elig)
    );

    irq_pick #(.N_DEV(N_DEV)) u_pick (
        .elig_i(elig),
        .prio_i(prio_i),
        .vec_i (vec_i),
        .win_o (win)
    );

    irq_grant u_grant (
        .clk       (clk),
        .rst       (rst),
        .eoi_i     (eoi_i),
        .cur_prio_i(cur_prio_i),
        .win_i     (win),
        .take_o    (take_o),
        .super_o   (super_o),
        .vec_o     (vec_o),
        .new_prio_o(new_prio_o)
    );

    assign isr_addr_o = ADDR_W'(TBL_BASE) + ADDR_W'(vec_o);
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
    localparam int CLK_P = 10;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] en = '0;
    logic [N*3-1:0] prio_f;
    logic [N*8-1:0] vec_f;
    logic [2:0] cur = '0;
    logic eoi = 1'b0;
    logic take, sup;
    logic [7:0] vec;
    logic [2:0] np;
    logic [15:0] addr;

    int prio_a [N];
    int vec_a [N];
    int m_take, m_vec, m_np;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            prio_f[i*3 +: 3] = 3'(prio_a[i]);
            vec_f[i*8 +: 8]  = 8'(vec_a[i]);
        end
    end

    irq_arbiter u0 (
        .clk(clk), .rst(rst), .req_i(req), .en_i(en), .prio_i(prio_f), .vec_i(vec_f),
        .cur_prio_i(cur), .eoi_i(eoi), .take_o(take), .super_o(sup), .vec_o(vec),
        .new_prio_o(np), .isr_addr_o(addr)
    );

    // Behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_take = 0; m_vec = 0; m_np = 0;
        end else begin
            int best, bp;
            best = -1; bp = -1;
            m_take = 0;
            if (eoi) begin
                for (int i = 0; i < N; i++)
                    if (req[i] && en[i] && prio_a[i] > bp) begin
                        best = i; bp = prio_a[i];
                    end
                if (best >= 0 && bp > int'(cur)) begin
                    m_take = 1; m_vec = vec_a[best]; m_np = bp;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(int'(take) == m_take, "R6 take", int'(take), m_take);
            chk(int'(sup) == m_take, "R6 super", int'(sup), m_take);
            chk(int'(vec) == m_vec, "R7 vec", int'(vec), m_vec);
            chk(int'(np) == m_np, "R7 new_prio", int'(np), m_np);
            chk(int'(addr) == 256 + m_vec, "R8 addr", int'(addr), 256 + m_vec);
        end
    end

    // Drives one strobe and leaves the bench on the falling edge where the result is visible.
    task automatic strobe;
        @(negedge clk) eoi = 1'b1;
        @(negedge clk) eoi = 1'b0;
    endtask

    task automatic clear_devs;
        req = '0; en = '0;
        for (int i = 0; i < N; i++) prio_a[i] = 0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            vec_a[i] = 32 + 3*i; prio_a[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk(take == 0 && sup == 0, "R10 take/super", int'(take), 0);
        chk(vec == 0 && np == 0, "R10 vec/prio", int'(vec), 0);
        chk(addr == 16'h0100, "R10 addr", int'(addr), 256);
        rst = 1'b0;

        // R1: request without enable, then enable without request
        clear_devs(); prio_a[2] = 7; req[2] = 1; cur = 0;
        strobe();
        chk(take == 0, "R1 req only", int'(take), 0);
        req[2] = 0; en[2] = 1;
        strobe();
        chk(take == 0, "R1 en only", int'(take), 0);

        // R2: equal priority refused, higher accepted
        clear_devs(); prio_a[3] = 4; req[3] = 1; en[3] = 1; cur = 4;
        strobe();
        chk(take == 0, "R2 equal prio", int'(take), 0);
        cur = 3;
        strobe();
        chk(take == 1 && vec == 8'(vec_a[3]), "R2 higher prio", int'(vec), vec_a[3]);
        @(negedge clk);
        chk(take == 0, "R6 one cycle", int'(take), 0);

        // R3: highest priority wins
        clear_devs(); cur = 0;
        prio_a[1] = 2; prio_a[5] = 6; prio_a[6] = 5;
        req = 8'b0110_0010; en = 8'b0110_0010;
        strobe();
        chk(take == 1 && vec == 8'(vec_a[5]), "R3 max prio vec", int'(vec), vec_a[5]);
        chk(np == 3'd6, "R7 new prio", int'(np), 6);

        // R4: tie goes to lower index
        clear_devs(); prio_a[4] = 5; prio_a[6] = 5;
        req = 8'b0101_0000; en = 8'b0101_0000;
        strobe();
        chk(take == 1 && vec == 8'(vec_a[4]), "R4 tie", int'(vec), vec_a[4]);

        // R5: no strobe, no take
        clear_devs(); prio_a[7] = 7; req[7] = 1; en[7] = 1;
        repeat (6) begin
            @(negedge clk);
            chk(take == 0, "R5 no strobe", int'(take), 0);
        end

        // R9: nothing qualifies, outputs hold
        clear_devs(); prio_a[0] = 1; req[0] = 1; en[0] = 1; cur = 6;
        strobe();
        chk(take == 0 && vec == 8'(vec_a[4]) && np == 3'd5, "R9 hold", int'(vec), vec_a[4]);

        // Random phase, strobes never back to back
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            req = 8'($urandom); en = 8'($urandom); cur = 3'($urandom);
            for (int i = 0; i < N; i++) prio_a[i] = int'($urandom_range(0, 7));
            eoi = (!eoi) && ($urandom_range(0, 2) != 0);
        end
        @(negedge clk) eoi = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule